// File: doc/BRIEF.md
# Interrupt Controller with IRQ/FIQ Steering

This block gathers the level-sensitive request lines of a set of peripherals into one first-level interrupt controller. Each line is normally the OR of several status conditions inside its peripheral; the controller only sees that single bit. A per-source enable mask decides which lines may interrupt the processor. A per-source routing bit sends each enabled line either to the normal interrupt output or to the fast interrupt output.

Software reaches the block over a simple word-addressed register bus. Writes take effect on the clock edge. Reads return data in the same cycle. Three read-only views show the state of the lines: every active line, the enabled lines routed to the normal output, and the enabled lines routed to the fast output. The mask, routing and control words can be written and read back. A wake output tells an idle processor to resume. A control bit selects whether the mask also filters wake events or whether any active line wakes the processor.

Top module: `irq_steer_ctrl`

## Requirements
- R1: After reset the mask word, routing word and control word read as zero, and `irq_o`, `fiq_o` and `wake_o` are low.
- R2: The raw view (offset 0x00) shows every active source in its bit position, whatever the mask. It follows `src_i` one clock later: the value sampled at a rising edge is visible after that edge.
- R3: The normal view (offset 0x04) equals raw AND mask AND NOT routing. A routing bit of 0 selects the normal output, and a mask bit of 1 enables the source.
- R4: The fast view (offset 0x08) equals raw AND mask AND routing. A routing bit of 1 selects the fast output.
- R5: `irq_o` is high exactly when the normal view is non-zero, and `fiq_o` is high exactly when the fast view is non-zero.
- R6: The mask word (offset 0x0C) and the routing word (offset 0x10) are written when `bus_we` is high on a rising edge and read back unchanged. The control word (offset 0x14) keeps only bit 0, the idle-mask bit, and its other bits read as 0.
- R7: Writes to offsets 0x00, 0x04 and 0x08 change no state. Mask, routing and control read back unchanged afterwards, and the views keep their values.
- R8: When `cpu_idle` is high and the idle-mask bit is 0, `wake_o` is high if any raw bit is set, including masked sources.
- R9: When `cpu_idle` is high and the idle-mask bit is 1, `wake_o` is high only if some raw bit is set whose mask bit is also set.
- R10: `wake_o` is low whenever `cpu_idle` is low.
- R11: Reads of any offset outside the six listed return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | N_SRC | Level-sensitive request line of each source |
| cpu_idle | input | 1 | Processor is in its idle state |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, taken on the rising edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| wake_o | output | 1 | Wake request to an idle processor |

## Verification
The assertions assume that the request lines and the bus inputs are stable around each rising edge. They also assume that a read of a view refers to the lines sampled at the previous edge, and that `cpu_idle` is a plain level from the processor with no handshake. The bench drives every input on the falling edge and checks outputs one falling edge later, so each sampled value is settled. Sources change only between register accesses, which keeps every expected view a function of the lines and configuration the bench last applied.

// File: rtl/irqc_pkg.sv
// Package irqc_pkg
// Purpose : register offsets and control bit position shared by the
//           interrupt steering controller and its checker.
// Assumes : byte addresses, one 32-bit word per register.
package irqc_pkg;
    localparam int unsigned OFF_RAW   = 32'h00;
    localparam int unsigned OFF_NORM  = 32'h04;
    localparam int unsigned OFF_FAST  = 32'h08;
    localparam int unsigned OFF_MASK  = 32'h0C;
    localparam int unsigned OFF_ROUTE = 32'h10;
    localparam int unsigned OFF_CTRL  = 32'h14;
    localparam int unsigned CTRL_IDLE_MASK_BIT = 0;
endpackage

// File: rtl/irqc_src_reg.sv
// Module irqc_src_reg
// Purpose : samples the raw request lines once per clock, giving the
//           one-cycle latency from request line to pending views.
// Assumes : request lines are level-sensitive and already synchronous.
module irqc_src_reg #(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    output logic [N_SRC-1:0] raw_q
);
    // capture the request lines, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= src_i;
    end
endmodule

// File: rtl/irqc_cfg_regs.sv
// Module irqc_cfg_regs
// Purpose : holds the writable mask, routing and control state and
//           decodes bus writes to them; other offsets are not stored.
// Assumes : N_SRC <= DATA_W; full-address decode, no byte enables.
module irqc_cfg_regs
    import irqc_pkg::*;
#(
    parameter int N_SRC  = 32,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [N_SRC-1:0]  mask_q,
    output logic [N_SRC-1:0]  route_q,
    output logic              idle_mask_q
);
    localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFF_MASK);
    localparam logic [ADDR_W-1:0] A_ROUTE = ADDR_W'(OFF_ROUTE);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);

    logic wr_mask, wr_route, wr_ctrl;

    // decode which stored word this write targets
    always_comb begin
        wr_mask  = bus_we && (bus_addr == A_MASK);
        wr_route = bus_we && (bus_addr == A_ROUTE);
        wr_ctrl  = bus_we && (bus_addr == A_CTRL);
    end

    // update the enable mask
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= bus_wdata[N_SRC-1:0];
    end

    // update the normal/fast routing word
    always_ff @(posedge clk) begin
        if (!rst_n)        route_q <= '0;
        else if (wr_route) route_q <= bus_wdata[N_SRC-1:0];
    end

    // update the idle-mask control bit
    always_ff @(posedge clk) begin
        if (!rst_n)       idle_mask_q <= 1'b0;
        else if (wr_ctrl) idle_mask_q <= bus_wdata[CTRL_IDLE_MASK_BIT];
    end
endmodule

// File: rtl/irqc_steer.sv
// Module irqc_steer
// Purpose : splits enabled sources between the normal and fast outputs,
//           reduces each group to a request, and forms the wake request.
// Assumes : routing bit 1 selects fast; mask bit 1 enables.
module irqc_steer #(
    parameter int N_SRC = 32
) (
    input  logic [N_SRC-1:0] raw_q,
    input  logic [N_SRC-1:0] mask_q,
    input  logic [N_SRC-1:0] route_q,
    input  logic             idle_mask_q,
    input  logic             cpu_idle,
    output logic [N_SRC-1:0] norm_pend,
    output logic [N_SRC-1:0] fast_pend,
    output logic             irq_o,
    output logic             fiq_o,
    output logic             wake_o
);
    logic [N_SRC-1:0] enabled;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        // per-source enable and routing choice
        always_comb begin
            enabled[i]   = raw_q[i] & mask_q[i];
            norm_pend[i] = enabled[i] & ~route_q[i];
            fast_pend[i] = enabled[i] &  route_q[i];
        end
    end

    // reduce each group to one request, and choose the wake filter
    always_comb begin
        irq_o  = |norm_pend;
        fiq_o  = |fast_pend;
        wake_o = cpu_idle && (idle_mask_q ? (|enabled) : (|raw_q));
    end
endmodule

// File: rtl/irq_steer_ctrl.sv
// Module irq_steer_ctrl
// Purpose : top of the first-level interrupt controller: samples request
//           lines, holds configuration, steers to normal/fast outputs,
//           and serves register reads combinationally.
// Assumes : N_SRC <= DATA_W; reads have no side effect.
module irq_steer_ctrl
    import irqc_pkg::*;
#(
    parameter int N_SRC  = 32,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_i,
    input  logic              cpu_idle,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              fiq_o,
    output logic              wake_o
);
    logic [N_SRC-1:0] raw_q, mask_q, route_q, norm_pend, fast_pend;
    logic             idle_mask_q;

    irqc_src_reg #(.N_SRC(N_SRC)) u_src (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .raw_q(raw_q)
    );

    irqc_cfg_regs #(.N_SRC(N_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .mask_q(mask_q), .route_q(route_q),
        .idle_mask_q(idle_mask_q)
    );

    irqc_steer #(.N_SRC(N_SRC)) u_steer (
        .raw_q(raw_q), .mask_q(mask_q), .route_q(route_q),
        .idle_mask_q(idle_mask_q), .cpu_idle(cpu_idle),
        .norm_pend(norm_pend), .fast_pend(fast_pend),
        .irq_o(irq_o), .fiq_o(fiq_o), .wake_o(wake_o)
    );

    // select the word addressed by the bus, zero for unmapped offsets
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFF_RAW):   bus_rdata[N_SRC-1:0] = raw_q;
            ADDR_W'(OFF_NORM):  bus_rdata[N_SRC-1:0] = norm_pend;
            ADDR_W'(OFF_FAST):  bus_rdata[N_SRC-1:0] = fast_pend;
            ADDR_W'(OFF_MASK):  bus_rdata[N_SRC-1:0] = mask_q;
            ADDR_W'(OFF_ROUTE): bus_rdata[N_SRC-1:0] = route_q;
            ADDR_W'(OFF_CTRL):  bus_rdata[CTRL_IDLE_MASK_BIT] = idle_mask_q;
            default:            bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_steer_ctrl_chk.sv
// Module irq_steer_ctrl_chk
// Purpose : property checks on the steering controller, bound to its top.
// Assumes : synchronous active-low reset; inputs settle before each edge.
module irq_steer_ctrl_chk
    import irqc_pkg::*;
#(
    parameter int N_SRC  = 32,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_SRC-1:0]  src_i,
    input logic              cpu_idle,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq_o,
    input logic              fiq_o,
    input logic              wake_o,
    input logic [N_SRC-1:0]  raw_q,
    input logic [N_SRC-1:0]  mask_q,
    input logic [N_SRC-1:0]  route_q,
    input logic              idle_mask_q
);
    AST_RAW_FOLLOWS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> raw_q == $past(src_i)); // R2
    AST_RAW_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFF_RAW)) |-> bus_rdata[N_SRC-1:0] == raw_q); // R2
    AST_IRQ_NEEDS_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> |(raw_q & mask_q & ~route_q)); // R3
    AST_FIQ_NEEDS_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> |(raw_q & mask_q & route_q)); // R4
    AST_NO_OUT_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq_o && !fiq_o); // R5
    AST_RO_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr <= ADDR_W'(OFF_FAST)) |=>
        $stable(mask_q) && $stable(route_q) && $stable(idle_mask_q)); // R7
    AST_IDLE_MASK_FILTERS: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_o && idle_mask_q) |-> |(raw_q & mask_q)); // R9
    AST_WAKE_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> cpu_idle); // R10
endmodule

bind irq_steer_ctrl irq_steer_ctrl_chk #(
    .N_SRC(N_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .cpu_idle(cpu_idle),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o), .wake_o(wake_o), .raw_q(raw_q),
    .mask_q(mask_q), .route_q(route_q), .idle_mask_q(idle_mask_q)
);

// File: tb/irq_steer_ctrl_bench.sv
module irq_steer_ctrl_bench;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] src = '0;
    logic        idle = 1'b0;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, fiq, wake;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [31:0] m_mask = '0, m_route = '0, m_src = '0;
    logic        m_dim = 1'b0;

    always #10 clk = ~clk;

    irq_steer_ctrl u_irq_steer_ctrl (
        .clk(clk), .rst_n(rst_n), .src_i(src), .cpu_idle(idle),
        .bus_addr(addr), .bus_we(we), .bus_wdata(wdata), .bus_rdata(rdata),
        .irq_o(irq), .fiq_o(fiq), .wake_o(wake)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; we = 1'b1;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        addr = a; #1;
        chk(req, rdata, exp);
    endtask

    task automatic set_src(input logic [31:0] v);
        @(negedge clk); src = v; m_src = v;
        @(negedge clk);
    endtask

    task automatic chk_views(input string req);
        rd_chk(req, 8'h00, m_src);
        rd_chk(req, 8'h04, m_src & m_mask & ~m_route);
        rd_chk(req, 8'h08, m_src & m_mask & m_route);
        chk(req, {31'd0, irq}, {31'd0, |(m_src & m_mask & ~m_route)});
        chk(req, {31'd0, fiq}, {31'd0, |(m_src & m_mask & m_route)});
    endtask

    task automatic t_reset();
        rd_chk("R1", 8'h0C, 32'h0);
        rd_chk("R1", 8'h10, 32'h0);
        rd_chk("R1", 8'h14, 32'h0);
        chk("R1", {29'd0, irq, fiq, wake}, 32'h0);
    endtask

    task automatic t_raw_latency();
        @(negedge clk); src = 32'hA5A5_0003; addr = 8'h00; #1;
        chk("R2 before edge", rdata, 32'h0);
        m_src = 32'hA5A5_0003;
        @(negedge clk);
        rd_chk("R2 after edge", 8'h00, m_src);
        chk("R2 masked no irq", {30'd0, irq, fiq}, 32'h0);
    endtask

    task automatic t_steer();
        m_mask = 32'h0F0F_FFFF; wr(8'h0C, m_mask);
        m_route = 32'h0000_00F0; wr(8'h10, m_route);
        set_src(32'h0000_0010); chk_views("R4 R5 fast only");
        set_src(32'h0000_0001); chk_views("R3 R5 normal only");
        set_src(32'h8000_0000); chk_views("R3 masked bit");
        set_src(32'hFFFF_FFFF); chk_views("R3 R4 both");
        set_src(32'h0); chk_views("R5 idle lines");
    endtask

    task automatic t_rw();
        wr(8'h0C, 32'hDEAD_BEEF); m_mask = 32'hDEAD_BEEF;
        rd_chk("R6 mask", 8'h0C, 32'hDEAD_BEEF);
        wr(8'h10, 32'h1234_5678); m_route = 32'h1234_5678;
        rd_chk("R6 route", 8'h10, 32'h1234_5678);
        wr(8'h14, 32'hFFFF_FFFF); m_dim = 1'b1;
        rd_chk("R6 ctrl", 8'h14, 32'h1);
        wr(8'h14, 32'hFFFF_FFFE); m_dim = 1'b0;
        rd_chk("R6 ctrl clear", 8'h14, 32'h0);
    endtask

    task automatic t_ro();
        set_src(32'h0000_5A5A);
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h08, 32'hFFFF_FFFF);
        rd_chk("R7 mask kept", 8'h0C, m_mask);
        rd_chk("R7 route kept", 8'h10, m_route);
        rd_chk("R7 ctrl kept", 8'h14, {31'd0, m_dim});
        chk_views("R7 views kept");
    endtask

    task automatic t_wake();
        m_mask = 32'h0000_00FF; wr(8'h0C, m_mask);
        wr(8'h14, 32'h0); m_dim = 1'b0;
        set_src(32'h0001_0000);
        @(negedge clk); idle = 1'b1; #1;
        chk("R8 masked wakes", {31'd0, wake}, 32'h1);
        wr(8'h14, 32'h1); m_dim = 1'b1; #1;
        chk("R9 masked no wake", {31'd0, wake}, 32'h0);
        set_src(32'h0001_0004); #1;
        chk("R9 unmasked wakes", {31'd0, wake}, 32'h1);
        @(negedge clk); idle = 1'b0; #1;
        chk("R10 not idle", {31'd0, wake}, 32'h0);
        wr(8'h14, 32'h0); m_dim = 1'b0; #1;
        chk("R10 not idle dim0", {31'd0, wake}, 32'h0);
        set_src(32'h0);
    endtask

    task automatic t_unmapped();
        rd_chk("R11 0x18", 8'h18, 32'h0);
        rd_chk("R11 0x40", 8'h40, 32'h0);
        rd_chk("R11 0x0D", 8'h0D, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_raw_latency();
        t_steer();
        t_rw();
        t_ro();
        t_wake();
        t_unmapped();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule